// File: doc/BRIEF.md
# PTP System Time Unit

This block keeps a free-running precision time value split into a seconds field and a sub-seconds field, with one sub-second step equal to 2^-31 of a second. An addend accumulator runs on the reference clock and sets the rate. On every clock cycle a programmable addend is added into a wide accumulator. Each carry out of that accumulator advances the sub-seconds field by a programmed step. Software can trim the rate by staging a new addend and then loading it. Software can also move the time once by a signed offset.

A programmable target time is compared against the running time. While the comparator is armed, the first cycle in which the time is strictly past the target raises a trigger level for a downstream timer and sets a sticky event flag. The flag drives a maskable interrupt. Control, offset, addend, target, mask and status all sit behind a simple word-wide write/read register port, and the current time is also available on dedicated outputs.

Top module: `ptp_systime_unit`

## Requirements
- R1: After reset, both time fields, the trigger output, the interrupt and the control word (register 0) read zero.
- R2: Each clock, the active addend is added modulo 2^32 into the accumulator. Every carry out adds the step (register 1, low 8 bits) to the sub-seconds field. Addend 0x8000_0000 therefore gives one step every two cycles, and addend 0 stops the time.
- R3: When a step takes the sub-seconds field to 2^31 or beyond, the field keeps the remainder modulo 2^31 and the seconds field increments by one.
- R4: A value written to the addend staging register (register 2) has no effect on the time until bit 4 of the control word is set. One cycle later the staged value becomes active (readable at register 11), and bit 4 reads zero again.
- R5: Setting bit 3 of the control word applies the offset one cycle later. The offset is taken from register 3 (seconds) and register 4 (bits 30:0 sub-seconds). When bit 31 of register 4 is 0 the offset is added, and a sub-seconds overflow past 2^31 carries into the seconds. Bit 3 then reads zero.
- R6: When bit 31 of register 4 is 1, the offset is subtracted instead. A sub-seconds underflow borrows one from the seconds and leaves the sub-seconds field at the difference plus 2^31.
- R7: With bit 5 of the control word set, the first cycle in which the time is strictly greater than the target (register 5 seconds, register 6 sub-seconds) sets the trigger output, sets bit 9 of the status register (register 8) and clears bit 5, all on the next clock edge. A time equal to the target does not fire.
- R8: The interrupt is high while status bit 9 is set and bit 9 of the mask register (register 7) is clear. Writing 1 to status bit 9 clears it.
- R9: Writing 1 to control bit 5 re-arms the comparator and drops the trigger output. With bit 5 clear, a time past the target changes neither the trigger nor the status.
- R10: Register 9 reads the current seconds and register 10 reads the current sub-seconds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (4) | Register word index |
| reg_wdata | input | DATA_W (32) | Register write data |
| reg_rdata | output | DATA_W (32) | Register read data for reg_addr |
| time_sec | output | SEC_W (32) | Current seconds |
| time_sub | output | SUB_W (31) | Current sub-seconds |
| trig_out | output | 1 | Target-reached trigger level |
| irq | output | 1 | Masked target interrupt |

## Verification
The rate path is tested with a half-scale addend and with a near-full-scale addend. The half-scale addend tells a carry every second cycle apart from a carry every cycle. The near-full-scale addend drives the sub-seconds across 2^31 and shows the wrap into the seconds. With the time frozen by a zero addend, a positive offset that overflows and a negative offset that underflows give exact values, so a missing carry or borrow cannot hide. For the comparator, the time is set exactly equal to the target and then one step beyond it, which separates a strict comparison from an inclusive one. Re-arming with a far target, and disarming with a past target, show that only an armed comparator can fire.

// File: rtl/ptp_stu_pkg.sv
package ptp_stu_pkg;
   // register word indices
   localparam int ADR_CTRL   = 0;
   localparam int ADR_STEP   = 1;
   localparam int ADR_STAGE  = 2;
   localparam int ADR_OFSSEC = 3;
   localparam int ADR_OFSSUB = 4;
   localparam int ADR_TGTSEC = 5;
   localparam int ADR_TGTSUB = 6;
   localparam int ADR_MASK   = 7;
   localparam int ADR_STAT   = 8;
   localparam int ADR_NOWSEC = 9;
   localparam int ADR_NOWSUB = 10;
   localparam int ADR_ACTADD = 11;
   // control and event bit positions
   localparam int CTL_COARSE = 3;
   localparam int CTL_LOAD   = 4;
   localparam int CTL_ARM    = 5;
   localparam int EVT_BIT    = 9;
endpackage

// File: rtl/ptp_stu_regs.sv
module ptp_stu_regs
   import ptp_stu_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 4,
   parameter int SEC_W  = 32,
   parameter int SUB_W  = 31,
   parameter int ACC_W  = 32,
   parameter int STEP_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              fire,
   input  logic [SEC_W-1:0]  now_sec,
   input  logic [SUB_W-1:0]  now_sub,
   input  logic [ACC_W-1:0]  addend_act,
   output logic [DATA_W-1:0] rdata,
   output logic              coarse_go,
   output logic              addend_load,
   output logic              armed,
   output logic              rearm,
   output logic [STEP_W-1:0] step,
   output logic [ACC_W-1:0]  addend_stage,
   output logic [SEC_W-1:0]  ofs_sec,
   output logic [DATA_W-1:0] ofs_sub,
   output logic [SEC_W-1:0]  tgt_sec,
   output logic [SUB_W-1:0]  tgt_sub,
   output logic              evt_mask,
   output logic              evt_flag
);
   logic wr_ctrl, wr_stat;

   assign wr_ctrl = wr_en && (addr == ADDR_W'(ADR_CTRL));
   assign wr_stat = wr_en && (addr == ADDR_W'(ADR_STAT));
   assign rearm   = wr_ctrl && wdata[CTL_ARM];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         coarse_go    <= 1'b0;
         addend_load  <= 1'b0;
         armed        <= 1'b0;
         step         <= '0;
         addend_stage <= '0;
         ofs_sec      <= '0;
         ofs_sub      <= '0;
         tgt_sec      <= '0;
         tgt_sub      <= '0;
         evt_mask     <= 1'b0;
         evt_flag     <= 1'b0;
      end else begin
         // one-shot requests self-clear after one cycle
         coarse_go   <= 1'b0;
         addend_load <= 1'b0;
         if (fire) armed <= 1'b0;
         if (wr_ctrl) begin
            coarse_go   <= wdata[CTL_COARSE];
            addend_load <= wdata[CTL_LOAD];
            armed       <= wdata[CTL_ARM];
         end
         if (wr_en) begin
            if (addr == ADDR_W'(ADR_STEP))   step         <= wdata[STEP_W-1:0];
            if (addr == ADDR_W'(ADR_STAGE))  addend_stage <= wdata[ACC_W-1:0];
            if (addr == ADDR_W'(ADR_OFSSEC)) ofs_sec      <= wdata[SEC_W-1:0];
            if (addr == ADDR_W'(ADR_OFSSUB)) ofs_sub      <= wdata;
            if (addr == ADDR_W'(ADR_TGTSEC)) tgt_sec      <= wdata[SEC_W-1:0];
            if (addr == ADDR_W'(ADR_TGTSUB)) tgt_sub      <= wdata[SUB_W-1:0];
            if (addr == ADDR_W'(ADR_MASK))   evt_mask     <= wdata[EVT_BIT];
         end
         // a new event outranks a same-cycle clear
         if (fire)                          evt_flag <= 1'b1;
         else if (wr_stat && wdata[EVT_BIT]) evt_flag <= 1'b0;
      end
   end

   always_comb begin
      rdata = '0;
      case (addr)
         ADDR_W'(ADR_CTRL): begin
            rdata[CTL_COARSE] = coarse_go;
            rdata[CTL_LOAD]   = addend_load;
            rdata[CTL_ARM]    = armed;
         end
         ADDR_W'(ADR_STEP):   rdata[STEP_W-1:0] = step;
         ADDR_W'(ADR_STAGE):  rdata[ACC_W-1:0]  = addend_stage;
         ADDR_W'(ADR_OFSSEC): rdata[SEC_W-1:0]  = ofs_sec;
         ADDR_W'(ADR_OFSSUB): rdata             = ofs_sub;
         ADDR_W'(ADR_TGTSEC): rdata[SEC_W-1:0]  = tgt_sec;
         ADDR_W'(ADR_TGTSUB): rdata[SUB_W-1:0]  = tgt_sub;
         ADDR_W'(ADR_MASK):   rdata[EVT_BIT]    = evt_mask;
         ADDR_W'(ADR_STAT):   rdata[EVT_BIT]    = evt_flag;
         ADDR_W'(ADR_NOWSEC): rdata[SEC_W-1:0]  = now_sec;
         ADDR_W'(ADR_NOWSUB): rdata[SUB_W-1:0]  = now_sub;
         ADDR_W'(ADR_ACTADD): rdata[ACC_W-1:0]  = addend_act;
         default:             rdata             = '0;
      endcase
   end
endmodule

// File: rtl/ptp_stu_clock.sv
module ptp_stu_clock #(
   parameter int DATA_W = 32,
   parameter int SEC_W  = 32,
   parameter int SUB_W  = 31,
   parameter int ACC_W  = 32,
   parameter int STEP_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              coarse_go,
   input  logic              addend_load,
   input  logic [ACC_W-1:0]  addend_stage,
   input  logic [STEP_W-1:0] step,
   input  logic [SEC_W-1:0]  ofs_sec,
   input  logic [DATA_W-1:0] ofs_sub,
   output logic [SEC_W-1:0]  now_sec,
   output logic [SUB_W-1:0]  now_sub,
   output logic [ACC_W-1:0]  addend_act
);
   localparam int SIGN_POS = DATA_W - 1;

   logic [ACC_W-1:0] acc;
   logic [ACC_W:0]   acc_sum;
   logic             tick;
   logic [SUB_W:0]   step_sum, ofs_add, ofs_dif;
   logic [SUB_W-1:0] ofs_mag;
   logic             ofs_neg;
   logic [SEC_W-1:0] nxt_sec;
   logic [SUB_W-1:0] nxt_sub;

   assign acc_sum  = {1'b0, acc} + {1'b0, addend_act};
   assign tick     = acc_sum[ACC_W];
   assign step_sum = {1'b0, now_sub} + (SUB_W+1)'(step);
   assign ofs_mag  = ofs_sub[SUB_W-1:0];
   assign ofs_neg  = ofs_sub[SIGN_POS];
   assign ofs_add  = {1'b0, now_sub} + {1'b0, ofs_mag};
   assign ofs_dif  = {1'b0, now_sub} - {1'b0, ofs_mag};

   always_comb begin
      nxt_sec = now_sec;
      nxt_sub = now_sub;
      if (coarse_go) begin
         if (ofs_neg) begin
            // low bits of the wrapped difference equal diff + 2^SUB_W on borrow
            nxt_sub = ofs_dif[SUB_W-1:0];
            nxt_sec = now_sec - ofs_sec - SEC_W'(ofs_dif[SUB_W]);
         end else begin
            nxt_sub = ofs_add[SUB_W-1:0];
            nxt_sec = now_sec + ofs_sec + SEC_W'(ofs_add[SUB_W]);
         end
      end else if (tick) begin
         nxt_sub = step_sum[SUB_W-1:0];
         nxt_sec = now_sec + SEC_W'(step_sum[SUB_W]);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc        <= '0;
         addend_act <= '0;
         now_sec    <= '0;
         now_sub    <= '0;
      end else begin
         acc     <= acc_sum[ACC_W-1:0];
         now_sec <= nxt_sec;
         now_sub <= nxt_sub;
         if (addend_load) addend_act <= addend_stage;
      end
   end
endmodule

// File: rtl/ptp_stu_target.sv
module ptp_stu_target #(
   parameter int SEC_W     = 32,
   parameter int SUB_W     = 31,
   parameter bit STRICT_GT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEC_W-1:0] now_sec,
   input  logic [SUB_W-1:0] now_sub,
   input  logic [SEC_W-1:0] tgt_sec,
   input  logic [SUB_W-1:0] tgt_sub,
   input  logic             armed,
   input  logic             rearm,
   output logic             past_tgt,
   output logic             fire,
   output logic             trig_out
);
   localparam int CMP_W = SEC_W + SUB_W;

   logic [CMP_W-1:0] now_cat, tgt_cat;

   assign now_cat = {now_sec, now_sub};
   assign tgt_cat = {tgt_sec, tgt_sub};

   generate
      if (STRICT_GT) begin : g_strict
         assign past_tgt = now_cat > tgt_cat;
      end else begin : g_incl
         assign past_tgt = now_cat >= tgt_cat;
      end
   endgenerate

   assign fire = armed && past_tgt;

   always_ff @(posedge clk) begin
      if (!rst_n)     trig_out <= 1'b0;
      else if (rearm) trig_out <= 1'b0;
      else if (fire)  trig_out <= 1'b1;
   end
endmodule

// File: rtl/ptp_systime_unit.sv
module ptp_systime_unit #(
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 4,
   parameter int SEC_W     = 32,
   parameter int SUB_W     = 31,
   parameter int ACC_W     = 32,
   parameter int STEP_W    = 8,
   parameter bit STRICT_GT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic [SEC_W-1:0]  time_sec,
   output logic [SUB_W-1:0]  time_sub,
   output logic              trig_out,
   output logic              irq
);
   if (SUB_W >= DATA_W) begin : g_bad_sub
      $error("SUB_W must leave room for the offset sign bit");
   end
   if (SEC_W > DATA_W || ACC_W > DATA_W) begin : g_bad_word
      $error("SEC_W and ACC_W must fit in one data word");
   end
   if (STEP_W > SUB_W) begin : g_bad_step
      $error("STEP_W must not exceed SUB_W");
   end
   if (ADDR_W < 4) begin : g_bad_addr
      $error("ADDR_W must cover twelve registers");
   end

   logic              coarse_go, addend_load, armed, rearm;
   logic              past_tgt, fire, evt_mask, evt_flag;
   logic [STEP_W-1:0] step;
   logic [ACC_W-1:0]  addend_stage, addend_act;
   logic [SEC_W-1:0]  ofs_sec, tgt_sec;
   logic [DATA_W-1:0] ofs_sub;
   logic [SUB_W-1:0]  tgt_sub;

   ptp_stu_regs #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SEC_W(SEC_W),
      .SUB_W(SUB_W), .ACC_W(ACC_W), .STEP_W(STEP_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
      .wdata(reg_wdata), .fire(fire), .now_sec(time_sec),
      .now_sub(time_sub), .addend_act(addend_act), .rdata(reg_rdata),
      .coarse_go(coarse_go), .addend_load(addend_load), .armed(armed),
      .rearm(rearm), .step(step), .addend_stage(addend_stage),
      .ofs_sec(ofs_sec), .ofs_sub(ofs_sub), .tgt_sec(tgt_sec),
      .tgt_sub(tgt_sub), .evt_mask(evt_mask), .evt_flag(evt_flag)
   );

   ptp_stu_clock #(
      .DATA_W(DATA_W), .SEC_W(SEC_W), .SUB_W(SUB_W),
      .ACC_W(ACC_W), .STEP_W(STEP_W)
   ) u_clock (
      .clk(clk), .rst_n(rst_n), .coarse_go(coarse_go),
      .addend_load(addend_load), .addend_stage(addend_stage),
      .step(step), .ofs_sec(ofs_sec), .ofs_sub(ofs_sub),
      .now_sec(time_sec), .now_sub(time_sub), .addend_act(addend_act)
   );

   ptp_stu_target #(
      .SEC_W(SEC_W), .SUB_W(SUB_W), .STRICT_GT(STRICT_GT)
   ) u_target (
      .clk(clk), .rst_n(rst_n), .now_sec(time_sec), .now_sub(time_sub),
      .tgt_sec(tgt_sec), .tgt_sub(tgt_sub), .armed(armed),
      .rearm(rearm), .past_tgt(past_tgt), .fire(fire),
      .trig_out(trig_out)
   );

   assign irq = evt_flag && !evt_mask;
endmodule

// File: rtl/ptp_stu_chk.sv
module ptp_stu_chk #(
   parameter int SEC_W  = 32,
   parameter int SUB_W  = 31,
   parameter int STEP_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              coarse_go,
   input logic              addend_load,
   input logic              armed,
   input logic              past_tgt,
   input logic              trig_out,
   input logic              evt_flag,
   input logic              irq,
   input logic [STEP_W-1:0] step,
   input logic [SEC_W-1:0]  time_sec,
   input logic [SUB_W-1:0]  time_sub
);
   // R2
   step_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(coarse_go) && time_sec == $past(time_sec) && time_sub != $past(time_sub))
      |-> time_sub == SUB_W'($past(time_sub) + SUB_W'($past(step))));

   // R3
   sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(coarse_go) && time_sec != $past(time_sec))
      |-> time_sec == SEC_W'($past(time_sec) + 1'b1));

   // R4
   load_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      addend_load |=> !addend_load);

   // R5
   coarse_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      coarse_go |=> !coarse_go);

   // R7
   fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && past_tgt) |=> (evt_flag && !armed));

   // R8
   irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> evt_flag);

   // R9
   idle_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !armed |=> !$rose(trig_out));
endmodule

bind ptp_systime_unit ptp_stu_chk #(
   .SEC_W(SEC_W), .SUB_W(SUB_W), .STEP_W(STEP_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .coarse_go(coarse_go),
   .addend_load(addend_load), .armed(armed), .past_tgt(past_tgt),
   .trig_out(trig_out), .evt_flag(evt_flag), .irq(irq), .step(step),
   .time_sec(time_sec), .time_sub(time_sub)
);

// File: tb/test_ptp_systime_unit.sv
module test_ptp_systime_unit;
   localparam longint unsigned TWO31 = 64'h8000_0000;
   localparam longint unsigned TWO32 = 64'h1_0000_0000;
   localparam longint unsigned M32   = 64'hFFFF_FFFF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [31:0] time_sec;
   logic [30:0] time_sub;
   logic        trig_out, irq;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   ptp_systime_unit i_ptp_systime_unit (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .time_sec(time_sec),
      .time_sub(time_sub), .trig_out(trig_out), .irq(irq)
   );

   // behavioural reference state
   longint unsigned m_sec, m_sub, m_acc, m_add, m_stage, m_step;
   longint unsigned m_osec, m_osub, m_tsec, m_tsub;
   bit m_go, m_ld, m_arm, m_trig, m_flag, m_mask;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_sec = 0; m_sub = 0; m_acc = 0; m_add = 0; m_stage = 0; m_step = 0;
         m_osec = 0; m_osub = 0; m_tsec = 0; m_tsub = 0;
         m_go = 0; m_ld = 0; m_arm = 0; m_trig = 0; m_flag = 0; m_mask = 0;
      end else begin
         longint unsigned nsec, nsub, nacc, mag, d;
         bit gt, fire, tick, ngo, nld, narm, ntrig, nflag;
         gt   = (m_sec > m_tsec) || (m_sec == m_tsec && m_sub > m_tsub);
         fire = m_arm && gt;
         nacc = m_acc + m_add;
         tick = nacc >= TWO32;
         nacc = nacc & M32;
         nsec = m_sec; nsub = m_sub;
         if (m_go) begin
            mag = m_osub & (TWO31 - 1);
            if (m_osub >= TWO31) begin
               if (m_sub >= mag) begin nsub = m_sub - mag; nsec = (m_sec - m_osec) & M32; end
               else begin nsub = m_sub + TWO31 - mag; nsec = (m_sec - m_osec - 1) & M32; end
            end else begin
               nsub = m_sub + mag;
               nsec = m_sec + m_osec;
               if (nsub >= TWO31) begin nsub -= TWO31; nsec += 1; end
               nsec &= M32;
            end
         end else if (tick) begin
            nsub = m_sub + m_step;
            if (nsub >= TWO31) begin nsub -= TWO31; nsec = (m_sec + 1) & M32; end
         end
         ngo = 0; nld = 0;
         narm  = fire ? 1'b0 : m_arm;
         ntrig = fire ? 1'b1 : m_trig;
         nflag = fire ? 1'b1 : m_flag;
         if (m_ld) m_add = m_stage;
         if (reg_wr) begin
            d = longint'(reg_wdata);
            case (reg_addr)
               4'd0: begin
                  ngo = reg_wdata[3]; nld = reg_wdata[4]; narm = reg_wdata[5];
                  if (reg_wdata[5]) ntrig = 1'b0;
               end
               4'd1: m_step = d & 64'hFF;
               4'd2: m_stage = d;
               4'd3: m_osec = d;
               4'd4: m_osub = d;
               4'd5: m_tsec = d;
               4'd6: m_tsub = d & (TWO31 - 1);
               4'd7: m_mask = reg_wdata[9];
               4'd8: if (reg_wdata[9] && !fire) nflag = 1'b0;
               default: ;
            endcase
         end
         m_sec = nsec; m_sub = nsub; m_acc = nacc;
         m_go = ngo; m_ld = nld; m_arm = narm; m_trig = ntrig; m_flag = nflag;
      end
   end

   task automatic chk(input bit ok, input string tag, input longint unsigned act,
                      input longint unsigned exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   // cycle-by-cycle comparison against the reference
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(longint'(time_sec) == m_sec, "R2/R3/R5/R6 seconds vs model", longint'(time_sec), m_sec);
         chk(longint'(time_sub) == m_sub, "R2/R3/R5/R6 subsec vs model", longint'(time_sub), m_sub);
         chk(trig_out == m_trig, "R7/R9 trigger vs model", longint'(trig_out), longint'(m_trig));
         chk(irq == (m_flag && !m_mask), "R8 irq vs model", longint'(irq),
             longint'(m_flag && !m_mask));
      end
   end

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = 4'(a); reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      reg_addr = 4'(a);
      #1;
      d = reg_rdata;
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      #(8 * 150000);
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      logic [31:0] r;
      longint unsigned s0, u0, es, eu;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      chk(time_sec == 0 && time_sub == 0, "R1 time after reset", longint'(time_sub), 0);
      chk(!trig_out && !irq, "R1 trigger and irq after reset", longint'({trig_out, irq}), 0);
      rd(0, r);
      chk(r == 0, "R1 control after reset", longint'(r), 0);

      // R4: staged addend stays idle until loaded
      wr(1, 32'd3);
      wr(2, 32'h8000_0000);
      repeat (5) @(negedge clk);
      chk(time_sub == 0, "R4 staged addend idle", longint'(time_sub), 0);
      rd(11, r);
      chk(r == 0, "R4 active addend before load", longint'(r), 0);
      wr(0, 32'h10);
      @(negedge clk);
      rd(0, r);
      chk(r == 0, "R4 load bit self-clears", longint'(r), 0);
      rd(11, r);
      chk(r == 32'h8000_0000, "R4 active addend after load", longint'(r), 64'h8000_0000);

      // R2: half-scale addend gives one step every two cycles
      u0 = longint'(time_sub);
      repeat (20) @(negedge clk);
      chk(longint'(time_sub) - u0 == 30, "R2 ten steps in twenty cycles",
          longint'(time_sub) - u0, 30);

      // freeze with addend zero
      wr(2, 32'h0);
      wr(0, 32'h10);
      repeat (2) @(negedge clk);
      s0 = longint'(time_sec); u0 = longint'(time_sub);
      repeat (3) @(negedge clk);
      chk(longint'(time_sub) == u0, "R2 zero addend stops time", longint'(time_sub), u0);

      // R10
      rd(9, r);
      chk(longint'(r) == s0, "R10 seconds readback", longint'(r), s0);
      rd(10, r);
      chk(longint'(r) == u0, "R10 subsec readback", longint'(r), u0);

      // R5: positive offset with carry into seconds
      wr(3, 32'd2);
      wr(4, 32'h7FFF_FFF0);
      wr(0, 32'h08);
      @(negedge clk);
      eu = u0 + 64'h7FFF_FFF0; es = s0 + 2;
      if (eu >= TWO31) begin eu -= TWO31; es += 1; end
      chk(longint'(time_sub) == eu, "R5 positive offset subsec", longint'(time_sub), eu);
      chk(longint'(time_sec) == es, "R5 positive offset carry", longint'(time_sec), es);
      rd(0, r);
      chk(r == 0, "R5 coarse bit self-clears", longint'(r), 0);

      // R6: negative offset with borrow
      s0 = longint'(time_sec); u0 = longint'(time_sub);
      wr(3, 32'd1);
      wr(4, 32'h8000_0000 | 32'(u0 + 5));
      wr(0, 32'h08);
      @(negedge clk);
      chk(longint'(time_sub) == TWO31 - 5, "R6 negative offset subsec",
          longint'(time_sub), TWO31 - 5);
      chk(longint'(time_sec) == s0 - 2, "R6 negative offset borrow",
          longint'(time_sec), s0 - 2);

      // R3: run across the sub-second wrap
      s0 = longint'(time_sec); u0 = longint'(time_sub);
      wr(3, 32'd0);
      wr(4, 32'((TWO31 - 2) - u0));
      wr(0, 32'h08);
      @(negedge clk);
      chk(longint'(time_sub) == TWO31 - 2, "R3 set near wrap", longint'(time_sub), TWO31 - 2);
      wr(2, 32'hFFFF_FFFF);
      wr(0, 32'h10);
      repeat (6) @(negedge clk);
      chk(longint'(time_sec) == s0 + 1, "R3 seconds increment on wrap",
          longint'(time_sec), s0 + 1);
      chk(time_sub < 31'd40, "R3 subsec keeps remainder", longint'(time_sub), 0);
      wr(2, 32'h0);
      wr(0, 32'h10);
      repeat (2) @(negedge clk);

      // R7: equal does not fire, one step past fires
      s0 = longint'(time_sec); u0 = longint'(time_sub);
      wr(5, 32'(s0));
      wr(6, 32'(u0));
      wr(0, 32'h20);
      repeat (3) @(negedge clk);
      chk(!trig_out, "R7 equal time does not fire", longint'(trig_out), 0);
      wr(3, 32'd0);
      wr(4, 32'd1);
      wr(0, 32'h28);
      @(negedge clk);
      @(negedge clk);
      chk(trig_out, "R7 trigger after passing target", longint'(trig_out), 1);
      rd(8, r);
      chk(r[9], "R7 status bit 9 set", longint'(r), 64'h200);
      rd(0, r);
      chk(r == 0, "R7 arm bit cleared on fire", longint'(r), 0);
      chk(irq, "R8 irq with mask clear", longint'(irq), 1);

      // R8: mask and write-one-to-clear
      wr(7, 32'h200);
      chk(!irq, "R8 irq masked", longint'(irq), 0);
      rd(8, r);
      chk(r[9], "R8 status kept while masked", longint'(r), 64'h200);
      wr(7, 32'h0);
      chk(irq, "R8 irq after unmask", longint'(irq), 1);
      wr(8, 32'h200);
      chk(!irq, "R8 irq after clear", longint'(irq), 0);
      rd(8, r);
      chk(r == 0, "R8 status cleared", longint'(r), 0);

      // R9: re-arm drops trigger, disarmed comparator ignores a past target
      wr(5, 32'hFFFF_FFFF);
      wr(0, 32'h20);
      chk(!trig_out, "R9 re-arm drops trigger", longint'(trig_out), 0);
      repeat (3) @(negedge clk);
      chk(!trig_out, "R9 armed below far target", longint'(trig_out), 0);
      wr(0, 32'h0);
      wr(5, 32'h0);
      wr(6, 32'h0);
      repeat (4) @(negedge clk);
      chk(!trig_out, "R9 disarmed trigger stays low", longint'(trig_out), 0);
      rd(8, r);
      chk(r == 0, "R9 disarmed status stays clear", longint'(r), 0);
      chk(!irq, "R9 disarmed irq stays low", longint'(irq), 0);

      finish_run();
   end
endmodule